// File: doc/BRIEF.md
# Fast-Lock Timeout Sequencer

This block times the fast-lock phase of a frequency synthesizer loop. Configuration words of 24 bits arrive on a parallel port, qualified by a one-cycle write strobe. A word addressed to the charge-pump register sets one of three 9-bit timeouts. A word addressed to the main frequency register restarts all three timeouts from their programmed values.

Two timeouts decide how long the loop-filter switch controls stay asserted. When the third timeout runs out, the charge-pump current multiplier steps down from 64x to 1x. Everything runs on the PFD reference clock. The timeouts advance once every four reference cycles.

Between restarts the block sits idle: both switch controls are low and the multiplier stays at 1x. The usual setup writes the three timeouts first, with each switch timeout set to the current timeout plus 7. After that, each write to the frequency register starts one fast-lock episode.

Top module: `flt_seq`

## Requirements
- R1: After reset both switch outputs are low and `icp_mult_o` equals 1.
- R2: A write whose bits 2:0 are 000 is a restart. From the next cycle both switch outputs are high and `icp_mult_o` equals 64.
- R3: A write with bits 2:0 = 100 and bits 23:14 = 0x001 stores bits 13:5 as a timeout. Bits 4:3 pick the target: 00 sets the switch 1/2 timer, 01 the switch 3 timer and 10 the current timer.
- R4: Some writes change nothing. These are a charge-pump word with select 11, a charge-pump word whose bits 23:14 differ from 0x001, and a word with any other control code (for example 001). None of them alters a stored timeout or a running sequence.
- R5: `sw12_o` falls on the clock edge 4·V edges after the restart edge, where V is its timeout. A value of 0 behaves as 1.
- R6: `sw3_o` follows the same rule as R5 with its own timeout.
- R7: `icp_mult_o` stays at 64 until 4·V+4 edges after the restart, where V is the current timeout and 0 behaves as 1. It then halves once every 4 edges (32, 16, 8, 4, 2, 1) and holds at 1.
- R8: A restart during a ramp reloads 64 and starts all timers over. This holds even when it falls on the edge where a ramp step would happen.
- R9: A timeout written while a sequence is running leaves that run unchanged. The new value applies from the next restart.
- R10: `icp_mult_o` always holds exactly one of 1, 2, 4, 8, 16, 32 or 64. Apart from a restart, it changes only by halving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PFD reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for `data_i` |
| data_i | input | 24 | Register word; bits 2:0 address the register |
| sw12_o | output | 1 | Switch 1/2 close control |
| sw3_o | output | 1 | Switch 3 close control |
| icp_mult_o | output | 7 | Charge-pump current multiplier (binary value) |

## Verification
A restart and a tick of the divide-by-four prescaler can land on the same clock edge. On that edge a timer may also be about to expire or the ramp may be about to halve. The bench provokes this by writing the frequency register exactly 16 edges after a restart, with the current timeout at 2, so the write meets the edge where the multiplier would step from 32 to 16. The check is that the multiplier returns to 64 and both switches stay high. After that, the whole sequence must repeat with edge counts measured from the second restart.

// File: rtl/flt_pkg.sv
package flt_pkg;
  localparam int unsigned WORD_W    = 24;
  localparam int unsigned VAL_W     = 9;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned CTL_W     = 3;
  localparam int unsigned RSV_W     = WORD_W - VAL_W - SEL_W - CTL_W;
  localparam int unsigned N_TIMERS  = 3;
  localparam int unsigned RAMP_STEPS = 6;
  localparam int unsigned MULT_W    = RAMP_STEPS + 1;
  localparam int unsigned TICK_DIV  = 4;

  localparam logic [CTL_W-1:0] CTL_FREQ = 3'b000;
  localparam logic [CTL_W-1:0] CTL_CP   = 3'b100;
  localparam logic [RSV_W-1:0] RSV_OK   = 10'h001;

  typedef enum logic [SEL_W-1:0] {
    SEL_SW12 = 2'b00,
    SEL_SW3  = 2'b01,
    SEL_ICP  = 2'b10,
    SEL_NONE = 2'b11
  } tsel_e;

  typedef struct packed {
    logic [RSV_W-1:0] rsv;
    logic [VAL_W-1:0] val;
    tsel_e            sel;
    logic [CTL_W-1:0] ctl;
  } cp_word_t;
endpackage

// File: rtl/flt_decode.sv
module flt_decode
  import flt_pkg::*;
#(
  parameter int unsigned NT = N_TIMERS
) (
  input  logic              wr_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              restart_o,
  output logic [NT-1:0]     load_o,
  output logic [VAL_W-1:0]  load_val_o
);
  cp_word_t w;
  logic     cp_ok;

  assign w          = cp_word_t'(data_i);
  assign restart_o  = wr_i && (w.ctl == CTL_FREQ);
  assign cp_ok      = wr_i && (w.ctl == CTL_CP) && (w.rsv == RSV_OK) && (w.sel != SEL_NONE);
  assign load_val_o = w.val;

  for (genvar i = 0; i < NT; i++) begin : g_ld
    assign load_o[i] = cp_ok && (w.sel == tsel_e'(i));
  end
endmodule

// File: rtl/flt_prescale.sv
module flt_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/flt_timer.sv
module flt_timer #(
  parameter int unsigned VW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [VW-1:0] load_val_i,
  input  logic          restart_i,
  input  logic          tick_i,
  output logic          busy_o,
  output logic          expire_o
);
  logic [VW-1:0] cfg_q, cnt_q;
  logic          run_q;
  logic          last;

  // value 0 and 1 both end on the first tick
  assign last     = (cnt_q <= VW'(1));
  assign expire_o = run_q && tick_i && last && !restart_i;
  assign busy_o   = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (load_i) cfg_q <= load_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= cfg_q;
      run_q <= 1'b1;
    end else if (run_q && tick_i) begin
      if (last) run_q <= 1'b0;
      else      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/flt_ramp.sv
module flt_ramp #(
  parameter int unsigned STEPS = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           restart_i,
  input  logic           start_i,
  input  logic           tick_i,
  output logic [STEPS:0] mult_o
);
  localparam logic [STEPS:0] M_MAX = {1'b1, {STEPS{1'b0}}};
  localparam logic [STEPS:0] M_MIN = {{STEPS{1'b0}}, 1'b1};

  logic [STEPS:0] mult_q;
  logic           act_q;

  assign mult_o = mult_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mult_q <= M_MIN;
      act_q  <= 1'b0;
    end else if (restart_i) begin
      mult_q <= M_MAX;
      act_q  <= 1'b0;
    end else if (start_i) begin
      act_q  <= 1'b1;
    end else if (act_q && tick_i) begin
      mult_q <= mult_q >> 1;
      if (mult_q == (M_MIN << 1)) act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/flt_seq.sv
module flt_seq
  import flt_pkg::*;
#(
  parameter int unsigned DIV   = TICK_DIV,
  parameter int unsigned STEPS = RAMP_STEPS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              sw12_o,
  output logic              sw3_o,
  output logic [STEPS:0]    icp_mult_o
);
  logic                restart;
  logic [N_TIMERS-1:0] load, busy, expire;
  logic [VAL_W-1:0]    load_val;
  logic                tick;

  flt_decode #(.NT(N_TIMERS)) u_dec (
    .wr_i       (wr_i),
    .data_i     (data_i),
    .restart_o  (restart),
    .load_o     (load),
    .load_val_o (load_val)
  );

  flt_prescale #(.DIV(DIV)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (restart),
    .tick_o  (tick)
  );

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
    flt_timer #(.VW(VAL_W)) u_tmr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load[i]),
      .load_val_i (load_val),
      .restart_i  (restart),
      .tick_i     (tick),
      .busy_o     (busy[i]),
      .expire_o   (expire[i])
    );
  end

  flt_ramp #(.STEPS(STEPS)) u_ramp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .start_i   (expire[SEL_ICP]),
    .tick_i    (tick),
    .mult_o    (icp_mult_o)
  );

  assign sw12_o = busy[SEL_SW12];
  assign sw3_o  = busy[SEL_SW3];

  logic unused_expire;
  assign unused_expire = ^{expire[SEL_SW12], expire[SEL_SW3], busy[SEL_ICP]};
endmodule

// File: rtl/flt_seq_chk.sv
module flt_seq_chk #(
  parameter int unsigned STEPS = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic [23:0]   data_i,
  input logic          sw12_o,
  input logic          sw3_o,
  input logic [STEPS:0] icp_mult_o
);
  logic rst_w;
  assign rst_w = wr_i && (data_i[2:0] == 3'b000);

  assert_mult_pow2_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(icp_mult_o) == 1);

  assert_mult_halve_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_w |=> (icp_mult_o == $past(icp_mult_o)) || (icp_mult_o == ($past(icp_mult_o) >> 1)));

  assert_restart_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_w |=> sw12_o && sw3_o && icp_mult_o[STEPS]);

  assert_sw12_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw12_o) |-> $past(rst_w));

  assert_sw3_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw3_o) |-> $past(rst_w));
endmodule

bind flt_seq flt_seq_chk #(.STEPS(STEPS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .data_i     (data_i),
  .sw12_o     (sw12_o),
  .sw3_o      (sw3_o),
  .icp_mult_o (icp_mult_o)
);

// File: tb/sim_flt_seq.sv
`timescale 1ns/1ps
module sim_flt_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [23:0] data_i = '0;
  logic        sw12_o, sw3_o;
  logic [6:0]  icp_mult_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  flt_seq u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .data_i(data_i),
    .sw12_o(sw12_o), .sw3_o(sw3_o), .icp_mult_o(icp_mult_o)
  );

  localparam logic [23:0] W_RESTART = 24'h5A5A58;

  function automatic logic [23:0] cpw(logic [1:0] sel, int val, logic [9:0] rsv = 10'h001);
    return {rsv, 9'(val), sel, 3'b100};
  endfunction

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(bit ok, string req, string what, int k, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s k=%0d actual=%0d expected=%0d", req, what, k, act, exp);
    end
  endtask

  task automatic wr(logic [23:0] w);
    wr_i = 1'b1;
    data_i = w;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_i = 1'b0;
    data_i = '0;
  endtask

  task automatic prog(int v12, int v3, int vi);
    wr(cpw(2'b00, v12));
    wr(cpw(2'b01, v3));
    wr(cpw(2'b10, vi));
  endtask

  // k = edges since restart edge; caller is at the negedge after edge k0
  task automatic watch(int v12, int v3, int vi, int k0, int k1, string tag);
    for (int k = k0; k < k1; k++) begin
      int ei, j, em;
      ei = 4 * eff(vi);
      j  = (k < ei) ? 0 : (k - ei) / 4;
      if (j > 6) j = 6;
      em = 64 >> j;
      chk(sw12_o == (k < 4 * eff(v12)), {tag, "/R5"}, "sw12", k, sw12_o, int'(k < 4 * eff(v12)));
      chk(sw3_o == (k < 4 * eff(v3)), {tag, "/R6"}, "sw3", k, sw3_o, int'(k < 4 * eff(v3)));
      chk(icp_mult_o == 7'(em), {tag, "/R7"}, "mult", k, icp_mult_o, em);
      @(negedge clk_i);
    end
  endtask

  task automatic t_reset;
    chk(sw12_o == 0, "R1", "sw12", 0, sw12_o, 0);
    chk(sw3_o == 0, "R1", "sw3", 0, sw3_o, 0);
    chk(icp_mult_o == 7'd1, "R1", "mult", 0, icp_mult_o, 1);
  endtask

  task automatic t_typical; // R2 R3
    prog(35, 35, 28);
    wr(W_RESTART);
    chk(icp_mult_o == 7'd64, "R2", "mult", 0, icp_mult_o, 64);
    watch(35, 35, 28, 0, 150, "R3");
  endtask

  task automatic t_spread;
    prog(7, 300, 100);
    wr(W_RESTART);
    watch(7, 300, 100, 0, 1215, "R3");
  endtask

  task automatic t_zero;
    prog(0, 1, 0);
    wr(W_RESTART);
    watch(0, 1, 0, 0, 40, "R5_zero");
  endtask

  task automatic t_ignored; // R4
    prog(5, 9, 3);
    wr(cpw(2'b11, 1));
    wr(cpw(2'b00, 1, 10'h000));
    wr(cpw(2'b01, 1, 10'h201));
    wr(cpw(2'b10, 1, 10'h003));
    wr(W_RESTART);
    watch(5, 9, 3, 0, 10, "R4");
    wr(24'h000001);
    watch(5, 9, 3, 11, 50, "R4");
  endtask

  task automatic t_midload; // R9
    prog(6, 8, 2);
    wr(W_RESTART);
    watch(6, 8, 2, 0, 3, "R9");
    wr(cpw(2'b00, 20));
    watch(6, 8, 2, 4, 45, "R9");
    wr(W_RESTART);
    watch(20, 8, 2, 0, 90, "R9");
  endtask

  task automatic t_ramp_restart; // R8: restart on a ramp-step tick
    prog(9, 9, 2);
    wr(W_RESTART);
    watch(9, 9, 2, 0, 15, "R8");
    wr(W_RESTART);
    chk(icp_mult_o == 7'd64, "R8", "mult", 0, icp_mult_o, 64);
    chk(sw12_o && sw3_o, "R8", "sw", 0, {sw12_o, sw3_o}, 3);
    watch(9, 9, 2, 0, 45, "R8");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_typical();
    t_spread();
    t_zero();
    t_ignored();
    t_midload();
    t_ramp_restart();
    finish_run();
  end
endmodule